// File: doc/BRIEF.md
# Cartridge Bank-Switching Address Translator

This block turns the processor and video addresses of a game cartridge into physical addresses for its program ROM and character memory. The processor programs it through a sixteen-byte register window. Each write there loads a bank number for one slot of the processor or video address space. The block then extends every bus address with the bank currently held for that slot. The translation is purely combinational from the held bank numbers.

Two of the registers select 2 KB character banks. Their most significant data bit also picks which of two 1 KB console RAM pages serves one pair of nametable quadrants. The two quadrant pairs are therefore steered independently, and no global mirroring mode exists. The top 8 KB processor slot never moves: it always maps to the last program bank. Bank numbers are cut down to the ROM that is present by two mask parameters.

Top module: `cart_bank_mapper`

## Requirements
- R1: Only a write strobe with cpu_addr[15:4] equal to 0x7EF changes any register; writes to every other address, including 0x7EE0, 0x7FF0 and 0xFEF0, leave every output unchanged.
- R2: A write to 0x7EF0 takes cpu_data[5:0] as the 2 KB character bank for video 0x0000-0x07FF and cpu_data[7] as the page bit for nametable quadrants 0 and 1. A write to 0x7EF1 does the same for video 0x0800-0x0FFF and quadrants 2 and 3. A 2 KB bank N supplies 1 KB unit 2N when ppu_addr[10] is 0 and unit 2N+1 when it is 1.
- R3: Writes to 0x7EF2, 0x7EF3, 0x7EF4 and 0x7EF5 take all eight data bits as the 1 KB character bank for video 0x1000, 0x1400, 0x1800 and 0x1C00.
- R4: The 8 KB program bank for processor 0x8000 is loaded by 0x7EFA or 0x7EFB. The bank for 0xA000 is loaded by 0x7EFC or 0x7EFD. The bank for 0xC000 is loaded by 0x7EFE or 0x7EFF.
- R5: Processor addresses 0xE000-0xFFFF always map to program bank PRG_MASK, the last bank, whatever has been written.
- R6: Writes to 0x7EF6 through 0x7EF9 change no register and no output.
- R7: nt_page equals the quadrant 0/1 page bit when ppu_addr[11] is 0, and the quadrant 2/3 page bit when it is 1.
- R8: prg_addr is {bank AND PRG_MASK, cpu_addr[12:0]} for cpu_addr[15]=1, where cpu_addr[14:13] picks the slot. chr_addr is {1 KB unit AND CHR_MASK, ppu_addr[9:0]}, where ppu_addr[12:10] picks the slot.
- R9: Reset clears every switchable bank number and both page bits to zero.
- R10: A register write takes effect at the rising clock edge on which cpu_wr is high. The outputs follow address changes with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_data | input | 8 | Processor write data |
| cpu_wr | input | 1 | Processor write strobe, sampled at the clock edge |
| ppu_addr | input | 14 | Video address |
| prg_addr | output | PRG_BANK_W+13 | Physical program ROM address |
| chr_addr | output | CHR_BANK_W+10 | Physical character memory address |
| nt_page | output | 1 | Console nametable RAM page for the current video address |

## Verification
The checker verifies the decoding on every cycle. Writes outside the window or to the four dead addresses must leave the register set unchanged. A write to the first 2 KB register and to either alias of the first program register must land one edge later. The checker also holds on every cycle the fixed top program slot, the pass-through of the in-page offsets and the quadrant steering of nt_page. Only the bench scenarios can show the full map from each written value to each address slot, the reset contents, the alias pairs of the later program registers, and the masking of oversized bank numbers.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    localparam int NUM_PRG_REGS = 3;
    localparam int NUM_CHR1K    = 4;
    localparam int NUM_CHR2K    = 2;

    typedef struct packed {
        logic [NUM_CHR2K-1:0]          nt_sel;
        logic [NUM_CHR2K-1:0][5:0]     chr2k;
        logic [NUM_CHR1K-1:0][7:0]     chr1k;
        logic [NUM_PRG_REGS-1:0][7:0]  prg;
    } bank_regs_t;

endpackage

// File: rtl/cbm_regs.sv
module cbm_regs
    import cbm_pkg::*;
#(
    parameter logic [11:0] WINDOW_HI = 12'h7EF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [15:0] addr,
    input  logic [7:0]  data,
    output bank_regs_t  regs
);

    logic       hit;
    logic [3:0] idx;

    assign hit = wr && (addr[15:4] == WINDOW_HI);
    assign idx = addr[3:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (hit) begin
            case (idx)
                4'h0, 4'h1: begin
                    regs.chr2k[idx[0]]  <= data[5:0];
                    regs.nt_sel[idx[0]] <= data[7];
                end
                4'h2, 4'h3, 4'h4, 4'h5:
                    regs.chr1k[2'(idx[1:0] - 2'd2)] <= data;
                4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF:
                    regs.prg[2'(idx[2:1] - 2'd1)] <= data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cbm_prg_map.sv
module cbm_prg_map
    import cbm_pkg::*;
#(
    parameter int          PRG_BANK_W = 5,
    parameter logic [7:0]  PRG_MASK   = 8'h1F,
    localparam int         PRG_AW     = PRG_BANK_W + 13
) (
    input  logic [15:0]       cpu_addr,
    input  bank_regs_t        regs,
    output logic [PRG_AW-1:0] prg_addr
);

    logic [3:0][7:0] slot_bank;
    logic [7:0]      masked;

    generate
        for (genvar i = 0; i < 4; i++) begin : g_slot
            if (i < NUM_PRG_REGS) begin : g_switch
                assign slot_bank[i] = regs.prg[i];
            end else begin : g_fixed
                assign slot_bank[i] = PRG_MASK;
            end
        end
    endgenerate

    always_comb begin
        masked   = slot_bank[cpu_addr[14:13]] & PRG_MASK;
        prg_addr = {masked[PRG_BANK_W-1:0], cpu_addr[12:0]};
    end

endmodule

// File: rtl/cbm_chr_map.sv
module cbm_chr_map
    import cbm_pkg::*;
#(
    parameter int          CHR_BANK_W = 8,
    parameter logic [7:0]  CHR_MASK   = 8'hFF,
    localparam int         CHR_AW     = CHR_BANK_W + 10
) (
    input  logic [13:0]       ppu_addr,
    input  bank_regs_t        regs,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              nt_page
);

    logic [7:0][7:0] slot_unit;
    logic [7:0]      masked;

    generate
        for (genvar i = 0; i < 8; i++) begin : g_slot
            if (i < 2 * NUM_CHR2K) begin : g_half
                assign slot_unit[i] = {1'b0, regs.chr2k[i / 2], 1'(i % 2)};
            end else begin : g_quarter
                assign slot_unit[i] = regs.chr1k[i - 2 * NUM_CHR2K];
            end
        end
    endgenerate

    always_comb begin
        masked   = slot_unit[ppu_addr[12:10]] & CHR_MASK;
        chr_addr = {masked[CHR_BANK_W-1:0], ppu_addr[9:0]};
        nt_page  = regs.nt_sel[ppu_addr[11]];
    end

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import cbm_pkg::*;
#(
    parameter int          PRG_BANK_W = 5,
    parameter logic [7:0]  PRG_MASK   = 8'h1F,
    parameter int          CHR_BANK_W = 8,
    parameter logic [7:0]  CHR_MASK   = 8'hFF,
    localparam int         PRG_AW     = PRG_BANK_W + 13,
    localparam int         CHR_AW     = CHR_BANK_W + 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_wr,
    input  logic [13:0]       ppu_addr,
    output logic [PRG_AW-1:0] prg_addr,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              nt_page
);

    bank_regs_t regs;

    cbm_regs #(
        .WINDOW_HI (12'h7EF)
    ) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cpu_wr),
        .addr  (cpu_addr),
        .data  (cpu_data),
        .regs  (regs)
    );

    cbm_prg_map #(
        .PRG_BANK_W (PRG_BANK_W),
        .PRG_MASK   (PRG_MASK)
    ) i_prg (
        .cpu_addr (cpu_addr),
        .regs     (regs),
        .prg_addr (prg_addr)
    );

    cbm_chr_map #(
        .CHR_BANK_W (CHR_BANK_W),
        .CHR_MASK   (CHR_MASK)
    ) i_chr (
        .ppu_addr (ppu_addr),
        .regs     (regs),
        .chr_addr (chr_addr),
        .nt_page  (nt_page)
    );

endmodule

// File: rtl/cbm_checker.sv
module cbm_checker
    import cbm_pkg::*;
#(
    parameter int          PRG_BANK_W = 5,
    parameter logic [7:0]  PRG_MASK   = 8'h1F,
    parameter int          CHR_BANK_W = 8,
    localparam int         PRG_AW     = PRG_BANK_W + 13,
    localparam int         CHR_AW     = CHR_BANK_W + 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_data,
    input logic              cpu_wr,
    input logic [13:0]       ppu_addr,
    input logic [PRG_AW-1:0] prg_addr,
    input logic [CHR_AW-1:0] chr_addr,
    input logic              nt_page,
    input bank_regs_t        regs
);

    p_window_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:4] != 12'h7EF) |=> $stable(regs));

    p_dead_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:4] == 12'h7EF &&
         cpu_addr[3:0] >= 4'h6 && cpu_addr[3:0] <= 4'h9) |=> $stable(regs));

    p_half_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'h7EF0) |=>
        (regs.chr2k[0] == $past(cpu_data[5:0]) && regs.nt_sel[0] == $past(cpu_data[7])));

    p_prg_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:1] == 15'h3F7D) |=> (regs.prg[0] == $past(cpu_data)));

    p_fixed_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b111) |-> (prg_addr[PRG_AW-1:13] == PRG_MASK[PRG_BANK_W-1:0]));

    p_offsets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_addr[9:0] == ppu_addr[9:0]) && (prg_addr[12:0] == cpu_addr[12:0]));

    p_quadrant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nt_page == (ppu_addr[11] ? regs.nt_sel[1] : regs.nt_sel[0]));

endmodule

bind cart_bank_mapper cbm_checker #(
    .PRG_BANK_W (PRG_BANK_W),
    .PRG_MASK   (PRG_MASK),
    .CHR_BANK_W (CHR_BANK_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_data (cpu_data),
    .cpu_wr   (cpu_wr),
    .ppu_addr (ppu_addr),
    .prg_addr (prg_addr),
    .chr_addr (chr_addr),
    .nt_page  (nt_page),
    .regs     (regs)
);

// File: tb/test_cart_bank_mapper.sv
`timescale 1ns/1ps
module test_cart_bank_mapper;

    localparam int         PW  = 5;
    localparam logic [7:0] PM  = 8'h1F;
    localparam int         CW  = 8;
    localparam logic [7:0] CM  = 8'hFF;
    localparam int         PAW = PW + 13;
    localparam int         CAW = CW + 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [15:0]    cpu_addr = '0;
    logic [7:0]     cpu_data = '0;
    logic           cpu_wr = 1'b0;
    logic [13:0]    ppu_addr = '0;
    logic [PAW-1:0] prg_addr;
    logic [CAW-1:0] chr_addr;
    logic           nt_page;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_prg [0:3];
    logic [5:0] m_c2  [0:1];
    logic       m_s   [0:1];
    logic [7:0] m_c1  [0:3];

    always #2.5 clk = ~clk;

    cart_bank_mapper #(
        .PRG_BANK_W (PW), .PRG_MASK (PM), .CHR_BANK_W (CW), .CHR_MASK (CM)
    ) i_cart_bank_mapper (
        .clk (clk), .rst_n (rst_n), .cpu_addr (cpu_addr), .cpu_data (cpu_data),
        .cpu_wr (cpu_wr), .ppu_addr (ppu_addr), .prg_addr (prg_addr),
        .chr_addr (chr_addr), .nt_page (nt_page)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin m_prg[i] = 8'h00; m_c1[i] = 8'h00; end
        for (int i = 0; i < 2; i++) begin m_c2[i] = 6'h00; m_s[i] = 1'b0; end
    endtask

    // Bank decoding from R1..R4 and R6
    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (a[15:4] == 12'h7EF) begin
            if (a[3:0] <= 4'h1) begin
                m_c2[a[0]] = d[5:0];
                m_s[a[0]]  = d[7];
            end else if (a[3:0] <= 4'h5) begin
                m_c1[a[3:0] - 4'h2] = d;
            end else if (a[3:0] >= 4'hA) begin
                m_prg[(a[3:0] - 4'hA) >> 1] = d;
            end
        end
    endtask

    function automatic logic [PAW-1:0] exp_prg(input logic [15:0] a);
        logic [7:0] b;
        b = (a[14:13] == 2'd3) ? PM : m_prg[a[14:13]];
        b = b & PM;
        return {b[PW-1:0], a[12:0]};
    endfunction

    function automatic logic [CAW-1:0] exp_chr(input logic [13:0] a);
        logic [7:0] u;
        if (a[12] == 1'b0) u = {1'b0, m_c2[a[11]], a[10]};
        else               u = m_c1[a[11:10]];
        u = u & CM;
        return {u[CW-1:0], a[9:0]};
    endfunction

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic probe(input logic [15:0] ca, input logic [13:0] pa, input string req);
        @(negedge clk);
        cpu_addr = ca; ppu_addr = pa;
        #1;
        if (ca[15]) check(prg_addr == exp_prg(ca), req, prg_addr, exp_prg(ca));
        check(chr_addr == exp_chr(pa), req, chr_addr, exp_chr(pa));
        if (pa[13]) check(nt_page == m_s[pa[11]], req, nt_page, m_s[pa[11]]);
    endtask

    task automatic probe_slots(input string req);
        for (int s = 0; s < 8; s++) begin
            probe(16'h8000 + 16'(s) * 16'h1000 + 16'h0123, 14'(s) * 14'h0400 + 14'h0155, req);
            probe(16'hC000, 14'h2000 + 14'(s) * 14'h0400 + 14'h0021, req);
        end
    endtask

    task automatic t_reset();
        model_reset();
        probe_slots("R9 reset contents");
    endtask

    task automatic t_chr_regs();
        cpu_write(16'h7EF0, 8'hA5);
        cpu_write(16'h7EF1, 8'h3C);
        cpu_write(16'h7EF2, 8'h81);
        cpu_write(16'h7EF3, 8'hFE);
        cpu_write(16'h7EF4, 8'h42);
        cpu_write(16'h7EF5, 8'h17);
        probe_slots("R2 R3 character banks");
        probe(16'h8000, 14'h2400, "R7 quadrant 1 page");
        probe(16'h8000, 14'h2C00, "R7 quadrant 3 page");
    endtask

    task automatic t_prg_aliases();
        cpu_write(16'h7EFA, 8'h03);
        probe_slots("R4 prg 0x7EFA");
        cpu_write(16'h7EFB, 8'h04);
        cpu_write(16'h7EFC, 8'h05);
        probe_slots("R4 prg 0x7EFB 0x7EFC");
        cpu_write(16'h7EFD, 8'h06);
        cpu_write(16'h7EFE, 8'h07);
        probe_slots("R4 prg 0x7EFD 0x7EFE");
        cpu_write(16'h7EFF, 8'h1E);
        probe_slots("R4 prg 0x7EFF");
    endtask

    task automatic t_ignored();
        for (int a = 6; a <= 9; a++) cpu_write(16'h7EF0 + 16'(a), 8'hFF);
        probe_slots("R6 dead addresses");
        cpu_write(16'h7EE0, 8'h9F);
        cpu_write(16'h7FF0, 8'h9F);
        cpu_write(16'hFEF0, 8'h9F);
        cpu_write(16'h7EFA ^ 16'h0100, 8'h11);
        probe_slots("R1 outside window");
    endtask

    task automatic t_timing();
        @(negedge clk);
        cpu_addr = 16'h7EF1; cpu_data = 8'h80 | 8'h05; cpu_wr = 1'b1;
        ppu_addr = 14'h2800;
        #1;
        check(nt_page == m_s[1], "R10 before edge", nt_page, m_s[1]);
        @(negedge clk);
        cpu_wr = 1'b0;
        model_write(16'h7EF1, 8'h85);
        #1;
        check(nt_page == 1'b1, "R10 after edge", nt_page, 1);
        cpu_addr = 16'hA000;
        #1;
        check(prg_addr == exp_prg(16'hA000), "R10 combinational prg", prg_addr, exp_prg(16'hA000));
    endtask

    task automatic t_sweep();
        for (int a = 16'h8000; a <= 16'hFFFF; a += 16'h0100)
            probe(16'(a) + 16'h0037, 14'((a - 16'h8000) >> 1) + 14'h0009, "R5 R8 address sweep");
        for (int a = 0; a < 16'h4000; a += 16'h0040)
            probe(16'hE000 + 16'(a), 14'(a), "R7 R8 video sweep");
    endtask

    task automatic t_mask();
        cpu_write(16'h7EFA, 8'hFF);
        cpu_write(16'h7EFC, 8'h20);
        cpu_write(16'h7EF0, 8'h3F);
        probe(16'h8ABC, 14'h0401, "R8 prg masking");
        probe(16'hA001, 14'h0000, "R8 prg masking upper");
        probe(16'hFFFF, 14'h07FF, "R5 R8 fixed with mask");
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_chr_regs();
        t_prg_aliases();
        t_ignored();
        t_timing();
        t_sweep();
        t_mask();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule